// File: doc/BRIEF.md
# Register Rename Status Table

This block holds the architectural register values of an out-of-order core together with one status entry per register. The status entry records which reservation-station tag will produce the register's next value. Tag zero means that no instruction in flight writes the register. Each register entry is a two-state machine. In `ENT_READY` the stored value is current and the tag is zero. In `ENT_WAIT` a producer is outstanding and the entry holds that producer's tag.

When an instruction issues, two lookup ports resolve its source registers. Each port returns either a ready value or the tag of the station that will supply it. In the same cycle the rename port stamps the issuing station's tag onto the destination register. When a functional unit broadcasts a result with its source tag, a waiting entry accepts the data only if its recorded tag still matches. A stale producer therefore cannot overwrite the value of a younger one, and write-after-write and write-after-read hazards disappear.

The entry transitions are:
- `rename` takes `ENT_READY` to `ENT_WAIT`.
- `retag` takes `ENT_WAIT` to `ENT_WAIT` when a newer rename arrives.
- `match` takes `ENT_WAIT` to `ENT_READY` on a broadcast carrying the recorded tag.
- `hold` keeps the state when nothing addresses the entry.

Top module: `rrs_table`

## Requirements
- R1: After reset, every register reads as ready with value zero and tag zero.
- R2: A lookup of a register in `ENT_READY` returns ready=1, its stored value and tag 0.
- R3: A rename (issue valid, destination index, nonzero tag) puts that register in `ENT_WAIT` from the next cycle. Lookups of the register then return ready=0, the issuing tag and data 0.
- R4: A broadcast whose tag equals a waiting register's tag moves that register to `ENT_READY` with the broadcast data from the next cycle. This applies to every register holding that tag.
- R5: A broadcast with a tag different from a waiting register's tag leaves that register waiting with its tag unchanged.
- R6: A second rename of the same register replaces its tag. A broadcast of the earlier tag then does not update the register, and only the newer tag's broadcast completes it.
- R7: When a rename and a broadcast of the register's current tag hit the same register in one cycle, the register is waiting on the new tag in the next cycle.
- R8: A lookup in the same cycle as a broadcast matching the looked-up register's tag returns the broadcast data with ready=1 and tag 0.
- R9: Lookups in the cycle of a rename see the register state from before that rename. A source equal to the destination therefore reads the old status.
- R10: The two lookup ports resolve their indices independently, including both addressing the same register.
- R11: A broadcast with tag 0 changes no ready register's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Rename request this cycle |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Issuing station tag, nonzero |
| src_a_idx | input | 4 | Lookup port A register index |
| src_b_idx | input | 4 | Lookup port B register index |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | 4 | Broadcasting station tag |
| res_data | input | 64 | Broadcast result value |
| src_a_ready | output | 1 | Port A operand is a value |
| src_a_tag | output | 4 | Port A producer tag (0 when ready) |
| src_a_data | output | 64 | Port A value (0 when not ready) |
| src_b_ready | output | 1 | Port B operand is a value |
| src_b_tag | output | 4 | Port B producer tag (0 when ready) |
| src_b_data | output | 64 | Port B value (0 when not ready) |

## Verification
The bench builds the table with its default parameters: 16 registers, 64-bit data and 4-bit tags. With only fifteen usable tags, randomly drawn renames and broadcasts often land on the same tag. That makes multi-register matches, stale-tag broadcasts after a retag and same-cycle rename/broadcast collisions common during the random phase, on top of the directed cases. Broadcast tags are partly drawn from tags currently recorded in the table, so matching completions happen often enough to cycle entries through all their transitions.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    localparam int unsigned RRS_REGS   = 16;
    localparam int unsigned RRS_DATA_W = 64;
    localparam int unsigned RRS_TAG_W  = 4;

    // Per-register entry state
    typedef enum logic {
        ENT_READY = 1'b0,
        ENT_WAIT  = 1'b1
    } ent_state_e;

endpackage

// File: rtl/rrs_entry.sv
module rrs_entry
    import rrs_pkg::*;
#(
    parameter int unsigned DATA_W = RRS_DATA_W,
    parameter int unsigned TAG_W  = RRS_TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_hit,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_data,
    output logic              is_wait,
    output logic              fwd_hit,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] val_o
);

    ent_state_e        st_q, st_d;
    logic [TAG_W-1:0]  tag_q, tag_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              match;

    assign match = (st_q == ENT_WAIT) && bc_valid && (bc_tag == tag_q);

    // Next-state logic: a rename always wins the status field
    always_comb begin
        st_d  = st_q;
        tag_d = tag_q;
        val_d = val_q;
        if (match) begin
            val_d = bc_data;
        end
        unique case (st_q)
            ENT_READY: begin
                if (ren_hit) begin
                    st_d  = ENT_WAIT;
                    tag_d = ren_tag;
                end
            end
            ENT_WAIT: begin
                if (ren_hit) begin
                    st_d  = ENT_WAIT;
                    tag_d = ren_tag;
                end else if (match) begin
                    st_d  = ENT_READY;
                    tag_d = '0;
                end
            end
            default: begin
                st_d  = ENT_READY;
                tag_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ENT_READY;
            tag_q <= '0;
            val_q <= '0;
        end else begin
            st_q  <= st_d;
            tag_q <= tag_d;
            val_q <= val_d;
        end
    end

    // Outputs
    always_comb begin
        is_wait = (st_q == ENT_WAIT);
        fwd_hit = match;
        tag_o   = tag_q;
        val_o   = val_q;
    end

    // R3
    ren_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ren_hit |=> (st_q == ENT_WAIT && tag_q == $past(ren_tag)));

    // R4
    match_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_hit && !ren_hit) |=> (st_q == ENT_READY && tag_q == '0 && val_q == $past(bc_data)));

    // R5
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENT_WAIT && !fwd_hit && !ren_hit) |=> (st_q == ENT_WAIT && $stable(tag_q)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENT_READY && !ren_hit) |=> (st_q == ENT_READY && $stable(val_q)));

endmodule

// File: rtl/rrs_read_port.sv
module rrs_read_port #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 64,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [IDX_W-1:0]                 idx,
    input  logic [NUM_REGS-1:0]              wait_vec,
    input  logic [NUM_REGS-1:0]              fwd_vec,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]   tag_arr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  val_arr,
    input  logic [DATA_W-1:0]                bc_data,
    output logic                             rdy,
    output logic [TAG_W-1:0]                 tag,
    output logic [DATA_W-1:0]                data
);

    // Ready value, same-cycle bypass, or producer tag
    always_comb begin
        rdy  = 1'b1;
        tag  = '0;
        data = val_arr[idx];
        if (wait_vec[idx]) begin
            if (fwd_vec[idx]) begin
                data = bc_data;
            end else begin
                rdy  = 1'b0;
                tag  = tag_arr[idx];
                data = '0;
            end
        end
    end

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vec[idx] |-> (rdy && data == bc_data));

endmodule

// File: rtl/rrs_table.sv
module rrs_table
    import rrs_pkg::*;
#(
    parameter int unsigned NUM_REGS = RRS_REGS,
    parameter int unsigned DATA_W   = RRS_DATA_W,
    parameter int unsigned TAG_W    = RRS_TAG_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [IDX_W-1:0]  iss_dst,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic [IDX_W-1:0]  src_a_idx,
    input  logic [IDX_W-1:0]  src_b_idx,
    input  logic              res_valid,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    output logic              src_a_ready,
    output logic [TAG_W-1:0]  src_a_tag,
    output logic [DATA_W-1:0] src_a_data,
    output logic              src_b_ready,
    output logic [TAG_W-1:0]  src_b_tag,
    output logic [DATA_W-1:0] src_b_data
);

    logic [NUM_REGS-1:0]             wait_vec;
    logic [NUM_REGS-1:0]             fwd_vec;
    logic [NUM_REGS-1:0][TAG_W-1:0]  tag_arr;
    logic [NUM_REGS-1:0][DATA_W-1:0] val_arr;

    logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
    logic [NUM_RD-1:0]               rd_rdy;
    logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_ent
            logic hit;
            assign hit = iss_valid && (iss_dst == IDX_W'(g));
            rrs_entry #(
                .DATA_W (DATA_W),
                .TAG_W  (TAG_W)
            ) u_ent (
                .clk      (clk),
                .rst_n    (rst_n),
                .ren_hit  (hit),
                .ren_tag  (iss_tag),
                .bc_valid (res_valid),
                .bc_tag   (res_tag),
                .bc_data  (res_data),
                .is_wait  (wait_vec[g]),
                .fwd_hit  (fwd_vec[g]),
                .tag_o    (tag_arr[g]),
                .val_o    (val_arr[g])
            );
        end

        for (g = 0; g < NUM_RD; g++) begin : g_rd
            rrs_read_port #(
                .NUM_REGS (NUM_REGS),
                .DATA_W   (DATA_W),
                .TAG_W    (TAG_W)
            ) u_rd (
                .clk      (clk),
                .rst_n    (rst_n),
                .idx      (rd_idx[g]),
                .wait_vec (wait_vec),
                .fwd_vec  (fwd_vec),
                .tag_arr  (tag_arr),
                .val_arr  (val_arr),
                .bc_data  (res_data),
                .rdy      (rd_rdy[g]),
                .tag      (rd_tag[g]),
                .data     (rd_data[g])
            );
        end
    endgenerate

    assign rd_idx[0]   = src_a_idx;
    assign rd_idx[1]   = src_b_idx;
    assign src_a_ready = rd_rdy[0];
    assign src_a_tag   = rd_tag[0];
    assign src_a_data  = rd_data[0];
    assign src_b_ready = rd_rdy[1];
    assign src_b_tag   = rd_tag[1];
    assign src_b_data  = rd_data[1];

    // R3
    iss_tag_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (iss_tag != '0));

    // R10
    port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_a_idx == src_b_idx) |-> (src_a_ready == src_b_ready && src_a_tag == src_b_tag
                                      && src_a_data == src_b_data));

endmodule

// File: tb/test_rrs_table.sv
`timescale 1ns/1ps
module test_rrs_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_dst = '0;
    logic [3:0]  iss_tag = '0;
    logic [3:0]  src_a_idx = '0;
    logic [3:0]  src_b_idx = '0;
    logic        res_valid = 1'b0;
    logic [3:0]  res_tag = '0;
    logic [63:0] res_data = '0;
    logic        src_a_ready, src_b_ready;
    logic [3:0]  src_a_tag, src_b_tag;
    logic [63:0] src_a_data, src_b_data;

    rrs_table i_rrs_table (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
        .src_a_ready(src_a_ready), .src_a_tag(src_a_tag), .src_a_data(src_a_data),
        .src_b_ready(src_b_ready), .src_b_tag(src_b_tag), .src_b_data(src_b_data)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          port;
        bit          rdy;
        logic [3:0]  tag;
        logic [63:0] data;
        string       req;
    } exp_t;

    exp_t        sb_q[$];
    event        drv_ev;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // Reference model of the table
    bit          m_pend [16];
    logic [3:0]  m_tag  [16];
    logic [63:0] m_val  [16];

    function automatic exp_t predict(int port, logic [3:0] idx, bit rv,
                                     logic [3:0] rtag, logic [63:0] rdata, string req);
        exp_t e;
        e.port = port;
        e.req  = req;
        if (!m_pend[idx]) begin
            e.rdy = 1'b1; e.tag = '0; e.data = m_val[idx];
        end else if (rv && rtag == m_tag[idx]) begin
            e.rdy = 1'b1; e.tag = '0; e.data = rdata;
        end else begin
            e.rdy = 1'b0; e.tag = m_tag[idx]; e.data = '0;
        end
        return e;
    endfunction

    // Driver: one cycle of stimulus, expectations pushed, model advanced
    task automatic step(bit iv, logic [3:0] idst, logic [3:0] itag,
                        bit rv, logic [3:0] rtag, logic [63:0] rdata,
                        logic [3:0] a, logic [3:0] b, string req);
        @(negedge clk);
        iss_valid = iv; iss_dst = idst; iss_tag = itag;
        res_valid = rv; res_tag = rtag; res_data = rdata;
        src_a_idx = a;  src_b_idx = b;
        sb_q.push_back(predict(0, a, rv, rtag, rdata, req));
        sb_q.push_back(predict(1, b, rv, rtag, rdata, req));
        for (int r = 0; r < 16; r++) begin
            if (m_pend[r] && rv && rtag == m_tag[r]) begin
                m_pend[r] = 1'b0; m_tag[r] = '0; m_val[r] = rdata;
            end
            if (iv && idst == 4'(r)) begin
                m_pend[r] = 1'b1; m_tag[r] = itag;
            end
        end
        ->drv_ev;
    endtask

    task automatic rd(logic [3:0] a, logic [3:0] b, string req);
        step(0, 0, 0, 0, 0, 0, a, b, req);
    endtask

    // Monitor: compares outputs 1 ns after the driver updates inputs
    initial begin
        forever begin
            @(drv_ev);
            #1;
            while (sb_q.size() > 0) begin
                exp_t e;
                bit          ar;
                logic [3:0]  at;
                logic [63:0] ad;
                e = sb_q.pop_front();
                ar = (e.port == 0) ? src_a_ready : src_b_ready;
                at = (e.port == 0) ? src_a_tag   : src_b_tag;
                ad = (e.port == 0) ? src_a_data  : src_b_data;
                n_run++;
                if (ar !== e.rdy || at !== e.tag || ad !== e.data) begin
                    n_fail++;
                    $display("FAIL %s port %0d: got rdy=%0b tag=%0d data=%h, expected rdy=%0b tag=%0d data=%h",
                             e.req, e.port, ar, at, ad, e.rdy, e.tag, e.data);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++) begin
            m_pend[r] = 1'b0; m_tag[r] = '0; m_val[r] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers ready with zero after reset
        for (int i = 0; i < 8; i++) rd(4'(2 * i), 4'(2 * i + 1), "R1");

        // R9: rename r3 while reading r3 sees old state
        step(1, 3, 5, 0, 0, 0, 3, 4, "R9");
        // R3 and R10: both ports see pending tag 5
        rd(3, 3, "R3");
        // R5: non-matching broadcast ignored
        step(0, 0, 0, 1, 7, 64'hdead, 3, 3, "R5");
        // R8: same-cycle bypass
        step(0, 0, 0, 1, 5, 64'h1111_2222_3333_4444, 3, 4, "R8");
        // R4/R2: register now holds broadcast value
        rd(3, 4, "R4");
        rd(3, 0, "R2");

        // R4: two registers with same tag both complete
        step(1, 6, 2, 0, 0, 0, 6, 7, "R3");
        step(1, 7, 2, 0, 0, 0, 6, 7, "R3");
        step(0, 0, 0, 1, 2, 64'hcafe_f00d, 0, 1, "R4");
        rd(6, 7, "R4");

        // R6: retag, stale broadcast ignored, newer completes
        step(1, 8, 3, 0, 0, 0, 8, 0, "R6");
        step(1, 8, 4, 0, 0, 0, 8, 0, "R6");
        step(0, 0, 0, 1, 3, 64'haaaa, 8, 8, "R6");
        rd(8, 8, "R6");
        step(0, 0, 0, 1, 4, 64'hbbbb, 0, 0, "R6");
        rd(8, 3, "R6");

        // R7: rename and matching broadcast collide
        step(1, 9, 6, 0, 0, 0, 9, 9, "R7");
        step(1, 9, 9, 1, 6, 64'hcccc, 0, 0, "R7");
        rd(9, 9, "R7");
        step(0, 0, 0, 1, 9, 64'hdddd, 0, 0, "R7");
        rd(9, 8, "R7");

        // R11: tag-zero broadcast leaves ready registers untouched
        step(0, 0, 0, 1, 0, 64'heeee, 0, 3, "R11");
        rd(0, 3, "R11");

        // R10: random traffic, independent port indices
        for (int k = 0; k < 400; k++) begin
            bit          iv, rv;
            logic [3:0]  rt;
            iv = 1'($urandom % 2);
            rv = 1'($urandom % 2);
            rt = ($urandom % 4 == 0) ? 4'($urandom % 16) : m_tag[$urandom % 16];
            step(iv, 4'($urandom % 16), 4'(1 + $urandom % 15), rv, rt,
                 {$urandom, $urandom}, 4'($urandom % 16), 4'($urandom % 16), "R10");
        end

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule